// File: doc/BRIEF.md
# Multi-Policy Victim Way Selector

This block decides which way of a set-associative cache is to be overwritten when an access misses. For every set it keeps an ordering of the ways from most recently touched to least recently touched. A run-time mode input chooses the rule: evict the least recently touched way, evict the most recently touched way, or evict a way drawn from a free-running pseudo-random generator. A way that is not valid is always taken first, whatever the rule.

The cache controller presents the set index of each access together with a hit flag and the hit way, or a miss flag. It also presents the valid bits of the ways in that set. On a miss the selector works out the victim in that cycle. It assumes that the controller fills the chosen way, so it marks that way as the newest. The victim is registered and shown, with a strobe, in the following cycle. A hit marks the hit way as the newest. Tags, data and memory traffic are handled outside the block. `WAYS` must be a power of two.

The control is a two-state machine. ST_IDLE means that no victim is being reported. ST_SHOW means that the victim of the previous cycle's miss is on the output. A miss moves the machine from either state to ST_SHOW. A cycle without a miss moves it from either state to ST_IDLE.

Top module: `repl_select`

## Requirements
- R1: When `mode` is 2'b00, the victim of a miss in a fully valid set is the way touched longest ago. The unused code 2'b11 behaves the same way.
- R2: When `mode` is 2'b01, the victim of a miss in a fully valid set is the way touched most recently.
- R3: When `mode` is 2'b10, the victim comes from the low bits of a 16-bit maximal-length LFSR. The LFSR is seeded non-zero at reset and steps every cycle. The victim is always below `WAYS`, and over many misses more than one way is chosen.
- R4: If any bit of `way_valid` is 0 on a miss, the victim is the lowest-numbered invalid way, in every mode.
- R5: A hit makes `hit_way` the newest way of its set. A miss makes the chosen victim the newest way of its set. If `miss` and `hit` are both high in one cycle, the miss wins and `hit_way` is ignored.
- R6: `victim_vld` is 1 exactly in the cycle after a cycle with `miss` high, and `victim_way` then holds that miss's victim. Back-to-back misses to one set see each other's update.
- R7: After reset `victim_vld` is 0. In every set way 0 is the oldest and way WAYS-1 is the newest.
- R8: With `WAYS` = 1 the victim is always way 0.
- R9: With two ways, the repeated pattern A,B,C (9 accesses) gives 9 misses under rule 2'b00 and 6 misses under rule 2'b01.
- R10: With two ways, the sequence A,A,B,B,C,C,A,B,C gives 6 misses under rule 2'b00 and 4 misses under rule 2'b01.
- R11: The ordering of each set changes only on accesses to that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Rule select: 00 oldest, 01 newest, 10 pseudo-random, 11 as 00 |
| acc_set | input | SET_W | Set index of the current access |
| hit | input | 1 | The access hit in `hit_way` |
| hit_way | input | WAY_W | Way that hit |
| miss | input | 1 | The access missed; a victim is wanted |
| way_valid | input | WAYS | Valid bits of the ways in `acc_set` |
| victim_way | output | WAY_W | Registered victim of the last miss |
| victim_vld | output | 1 | High in the cycle after a miss |

## Verification
Two actions can fall in the same cycle. The first is reporting the victim of one miss. The second is choosing a victim for the next miss to the same set, and that choice must already see the first miss's fill as the newest way. The bench provokes this by issuing misses on consecutive clocks to one fully valid set. Its queue model expects the victims to alternate between the two ways. The bench also drives `hit` and `miss` together and judges the outcome from the victim of the following miss.

// File: rtl/repl_pkg.sv
package repl_pkg;

    // Replacement rule codes carried on the mode input
    typedef enum logic [1:0] {
        POL_OLDEST = 2'b00,
        POL_NEWEST = 2'b01,
        POL_RAND   = 2'b10,
        POL_SPARE  = 2'b11
    } pol_e;

    // Reporting state of the selector
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } st_e;

    localparam int LFSR_W = 16;

endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
    parameter int                W    = 16,
    parameter logic [W-1:0]      SEED = 16'hACE1,
    parameter logic [W-1:0]      TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);

    logic [W-1:0] q_d;

    // Galois form: shift right, fold the taps in when a one drops out
    always_comb begin
        q_d = q >> 1;
        if (q[0]) begin
            q_d = q_d ^ TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEED;
        end else begin
            q <= q_d;
        end
    end

    // R3: a maximal sequence never reaches the all-zero lock-up state
    p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);

    // R3: the generator moves on every cycle
    p_lfsr_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q != $past(q));

endmodule

// File: rtl/repl_rank_tab.sv
module repl_rank_tab #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int SET_W = 3,
    parameter int WAY_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_en,
    input  logic [SET_W-1:0]            upd_set,
    input  logic [WAY_W-1:0]            upd_way,
    output logic [WAYS-1:0][WAY_W-1:0]  rd_rank
);

    // rank 0 = newest, rank WAYS-1 = oldest; each row is a permutation
    logic [WAYS-1:0][WAY_W-1:0] rank_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0] row_d;
    logic [WAY_W-1:0]           tgt_rank;

    assign rd_rank  = rank_q[upd_set];
    assign tgt_rank = rd_rank[upd_way];

    // Ways newer than the touched one age by one; the touched one becomes newest
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == upd_way) begin
                row_d[w] = '0;
            end else if (rd_rank[w] < tgt_rank) begin
                row_d[w] = rd_rank[w] + WAY_W'(1);
            end else begin
                row_d[w] = rd_rank[w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    rank_q[s][w] <= WAY_W'(WAYS - 1 - w);
                end
            end
        end else if (upd_en) begin
            rank_q[upd_set] <= row_d;
        end
    end

    // R5: the touched way is the newest of its set right after the update
    p_touch_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> rank_q[$past(upd_set)][$past(upd_way)] == '0);

endmodule

// File: rtl/repl_pick.sv
module repl_pick
    import repl_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  pol_e                        mode,
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][WAY_W-1:0]  rank,
    input  logic [WAY_W-1:0]            rnd,
    output logic [WAY_W-1:0]            victim
);

    generate
        if (WAYS == 1) begin : g_single
            logic unused_in;
            assign unused_in = ^{mode, valid, rank, rnd};
            assign victim    = '0;
        end else begin : g_multi
            logic [WAY_W-1:0] old_w;
            logic [WAY_W-1:0] new_w;

            always_comb begin
                old_w = '0;
                new_w = '0;
                for (int w = 0; w < WAYS; w++) begin
                    if (rank[w] == WAY_W'(WAYS - 1)) old_w = WAY_W'(w);
                    if (rank[w] == '0)               new_w = WAY_W'(w);
                end

                unique case (mode)
                    POL_NEWEST: victim = new_w;
                    POL_RAND:   victim = rnd;
                    default:    victim = old_w;
                endcase

                // Invalid ways override the rule; descending scan leaves the lowest
                for (int w = WAYS - 1; w >= 0; w--) begin
                    if (!valid[w]) victim = WAY_W'(w);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/repl_select.sv
module repl_select
    import repl_pkg::*;
#(
    parameter  int SETS  = 8,
    parameter  int WAYS  = 4,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [SET_W-1:0] acc_set,
    input  logic             hit,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             miss,
    input  logic [WAYS-1:0]  way_valid,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_vld
);

    st_e                        st_q, st_d;
    logic [LFSR_W-1:0]          lfsr_q;
    logic [WAYS-1:0][WAY_W-1:0] rank_row;
    logic [WAY_W-1:0]           victim_now;
    logic [WAY_W-1:0]           upd_way;
    logic                       upd_en;
    logic                       unused_hi;

    repl_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (lfsr_q)
    );

    assign unused_hi = ^lfsr_q[LFSR_W-1:WAY_W];

    // A miss fills the chosen way, so the miss takes precedence over a hit
    assign upd_en  = miss | hit;
    assign upd_way = miss ? victim_now : hit_way;

    repl_rank_tab #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .SET_W (SET_W),
        .WAY_W (WAY_W)
    ) u_rank (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .upd_set (acc_set),
        .upd_way (upd_way),
        .rd_rank (rank_row)
    );

    repl_pick #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_pick (
        .mode   (pol_e'(mode)),
        .valid  (way_valid),
        .rank   (rank_row),
        .rnd    (lfsr_q[WAY_W-1:0]),
        .victim (victim_now)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = miss ? ST_SHOW : ST_IDLE;
            ST_SHOW: st_d = miss ? ST_SHOW : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_way <= '0;
        end else if (miss) begin
            victim_way <= victim_now;
        end
    end

    assign victim_vld = (st_q == ST_SHOW);

    // R6: a miss is answered in the next cycle
    p_vld_after_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> victim_vld);

    // R6: no strobe without a miss in the cycle before
    p_vld_only_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !miss |=> !victim_vld);

    // R4: with an invalid way present, the reported victim was invalid
    p_invalid_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && (way_valid != '1)) |=>
            ((($past(way_valid) >> victim_way) & WAYS'(1)) == '0));

    generate
        if (WAYS == 1) begin : g_one_chk
            // R8: one candidate only
            p_one_way_r8: assert property (@(posedge clk) disable iff (!rst_n)
                victim_vld |-> victim_way == '0);
        end
    endgenerate

endmodule

// File: tb/repl_select_tb.sv
`timescale 1ns/1ps
module repl_select_tb_top;

    localparam int SETS = 4;
    localparam int WAYS = 2;
    localparam int SW   = 2;
    localparam int WW   = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode = 2'b00;
    logic [SW-1:0]   acc_set = '0;
    logic            hit = 1'b0;
    logic [WW-1:0]   hit_way = '0;
    logic            miss = 1'b0;
    logic [WAYS-1:0] way_valid = '0;
    logic [WW-1:0]   victim_way;
    logic            victim_vld;

    logic [1:0]      o_mode = 2'b00;
    logic            o_miss = 1'b0;
    logic            o_hit = 1'b0;
    logic            o_valid = 1'b0;
    logic [0:0]      o_victim;
    logic            o_vld;

    always #2.5 clk = ~clk;

    repl_select #(.SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .acc_set(acc_set),
        .hit(hit), .hit_way(hit_way), .miss(miss), .way_valid(way_valid),
        .victim_way(victim_way), .victim_vld(victim_vld)
    );

    repl_select #(.SETS(2), .WAYS(1)) one_i (
        .clk(clk), .rst_n(rst_n), .mode(o_mode), .acc_set(1'b0),
        .hit(o_hit), .hit_way(1'b0), .miss(o_miss), .way_valid(o_valid),
        .victim_way(o_victim), .victim_vld(o_vld)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ord [SETS][$];      // per set: front = newest way, back = oldest way
    int tagv [SETS][WAYS];
    bit vld  [SETS][WAYS];
    int last_victim;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            ord[s].delete();
            for (int w = WAYS - 1; w >= 0; w--) ord[s].push_back(w);
            for (int w = 0; w < WAYS; w++) begin
                vld[s][w]  = 1'b0;
                tagv[s][w] = -1;
            end
        end
    endtask

    task automatic touch(input int s, input int w);
        for (int i = 0; i < ord[s].size(); i++) begin
            if (ord[s][i] == w) begin
                ord[s].delete(i);
                break;
            end
        end
        ord[s].push_front(w);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; miss = 1'b0; hit = 1'b0; o_miss = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk(victim_vld == 1'b0, "R7 strobe low after reset", int'(victim_vld), 0);
    endtask

    // One access cycle; starts and ends just after a falling edge
    task automatic issue(input int s, input logic [1:0] md, input bit m, input bit h,
                         input int hw, input logic [WAYS-1:0] vb, input string req);
        int exp;
        exp = -1;
        if (m) begin
            if (md == 2'b01) exp = ord[s][0];
            else if (md == 2'b10) exp = -1;
            else exp = ord[s][$];
            for (int w = WAYS - 1; w >= 0; w--) if (!vb[w]) exp = w;
        end
        mode = md; acc_set = s[SW-1:0]; miss = m; hit = h;
        hit_way = hw[WW-1:0]; way_valid = vb;
        @(negedge clk);
        miss = 1'b0; hit = 1'b0;
        if (m) begin
            chk(victim_vld == 1'b1, {req, " R6 strobe"}, int'(victim_vld), 1);
            if (exp >= 0) chk(int'(victim_way) == exp, req, int'(victim_way), exp);
            else chk(int'(victim_way) < WAYS, {req, " R3 range"}, int'(victim_way), WAYS - 1);
            last_victim = int'(victim_way);
            touch(s, last_victim);
        end else begin
            chk(victim_vld == 1'b0, {req, " R6 no strobe"}, int'(victim_vld), 0);
            if (h) touch(s, hw);
        end
    endtask

    task automatic access(input int s, input int tag, input logic [1:0] md,
                          input string req, inout int misses);
        logic [WAYS-1:0] vb;
        int hw;
        hw = -1;
        for (int w = 0; w < WAYS; w++) begin
            vb[w] = vld[s][w];
            if (vld[s][w] && tagv[s][w] == tag) hw = w;
        end
        if (hw >= 0) begin
            issue(s, md, 1'b0, 1'b1, hw, vb, req);
        end else begin
            issue(s, md, 1'b1, 1'b0, 0, vb, req);
            misses++;
            tagv[s][last_victim] = tag;
            vld[s][last_victim]  = 1'b1;
        end
    endtask

    task automatic run_seq(input int seq[9], input logic [1:0] md, input int exp_m,
                           input string req);
        int misses;
        misses = 0;
        do_reset();
        for (int i = 0; i < 9; i++) access(1, seq[i], md, req, misses);
        chk(misses == exp_m, {req, " miss count"}, misses, exp_m);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s1[9] = '{0, 1, 2, 0, 1, 2, 0, 1, 2};
        int s2[9] = '{0, 0, 1, 1, 2, 2, 0, 1, 2};
        int seen0, seen1;

        // R7: reset ordering, way 0 oldest, way 1 newest
        do_reset();
        issue(1, 2'b00, 1'b1, 1'b0, 0, 2'b11, "R7 oldest after reset");
        do_reset();
        issue(1, 2'b01, 1'b1, 1'b0, 0, 2'b11, "R7 newest after reset");

        // R9 / R10: miss counts on a two-way set
        run_seq(s1, 2'b00, 9, "R9 oldest rule");
        run_seq(s1, 2'b01, 6, "R9 newest rule");
        run_seq(s2, 2'b00, 6, "R10 oldest rule");
        run_seq(s2, 2'b01, 4, "R10 newest rule");

        // R6 / R1: back-to-back misses on one set alternate under the oldest rule
        do_reset();
        issue(2, 2'b00, 1'b1, 1'b0, 0, 2'b11, "R1 back-to-back 1");
        issue(2, 2'b00, 1'b1, 1'b0, 0, 2'b11, "R1 back-to-back 2");
        issue(2, 2'b00, 1'b1, 1'b0, 0, 2'b11, "R1 back-to-back 3");
        issue(2, 2'b11, 1'b1, 1'b0, 0, 2'b11, "R1 spare code acts as oldest");
        issue(2, 2'b00, 1'b0, 1'b0, 0, 2'b11, "R6 idle cycle");

        // R2 after hits: a hit makes that way newest, newest rule evicts it
        issue(2, 2'b01, 1'b0, 1'b1, 0, 2'b11, "R5 hit way 0");
        issue(2, 2'b01, 1'b1, 1'b0, 0, 2'b11, "R2 newest after hit");

        // R5: miss and hit together, the miss wins
        do_reset();
        issue(3, 2'b00, 1'b1, 1'b1, 1, 2'b11, "R5 miss beats hit");
        issue(3, 2'b00, 1'b1, 1'b0, 0, 2'b11, "R5 hit way ignored");

        // R4: invalid ways first in every rule
        do_reset();
        issue(0, 2'b00, 1'b1, 1'b0, 0, 2'b10, "R4 invalid way 0 oldest rule");
        issue(0, 2'b01, 1'b1, 1'b0, 0, 2'b01, "R4 invalid way 1 newest rule");
        issue(0, 2'b10, 1'b1, 1'b0, 0, 2'b01, "R4 invalid way 1 random rule");
        issue(0, 2'b01, 1'b1, 1'b0, 0, 2'b00, "R4 lowest invalid");

        // R11: activity on set 0 leaves set 3 at its reset ordering
        issue(3, 2'b00, 1'b1, 1'b0, 0, 2'b11, "R11 untouched set");

        // R3: random rule stays in range and uses both ways
        seen0 = 0; seen1 = 0;
        for (int i = 0; i < 32; i++) begin
            issue(2, 2'b10, 1'b1, 1'b0, 0, 2'b11, "R3 random");
            if (last_victim == 0) seen0++;
            else seen1++;
            if (i % 3 == 0) issue(2, 2'b10, 1'b0, 1'b0, 0, 2'b11, "R3 gap");
        end
        chk(seen0 > 0, "R3 way 0 drawn", seen0, 1);
        chk(seen1 > 0, "R3 way 1 drawn", seen1, 1);

        // R8: single-way instance always returns way 0
        do_reset();
        o_valid = 1'b1;
        for (int md = 0; md < 4; md++) begin
            o_mode = md[1:0]; o_miss = 1'b1;
            @(negedge clk);
            o_miss = 1'b0;
            chk(o_vld == 1'b1, "R8 strobe", int'(o_vld), 1);
            chk(o_victim == 1'b0, "R8 single way", int'(o_victim), 0);
        end
        @(negedge clk);
        chk(o_vld == 1'b0, "R8 strobe drops", int'(o_vld), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule